// File: doc/BRIEF.md
# Start-Triggered Counter Flag Sequencer

This block pairs a three-state controller with a small datapath made of a binary counter and two single-bit flags. A start pulse, taken only while the block is idle, clears the counter and the terminating flag. The counter then steps once per clock. On every counting clock, one counter bit sets the step flag (E) and two counter bits together decide when counting ends. One clock after counting ends, the terminating flag (F) is raised and the block goes back to idle, holding its final values.

The counter increment, the E update and the next-state choice on a counting clock all use the counter value from before that edge, and all take effect on that same edge. With the default parameters, a run starts from zero, sees the stop condition when the counter holds 12, and leaves the counter at 13 with E = 1 and F = 1. A `busy` output shows that a run is in progress.

Top module: `ctr_flag_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `count` = 0, `flag_e` = 0, `flag_f` = 0 and `busy` = 0, and the controller is idle.
- R2: A rising edge with `start` = 1 while idle sets `count` to 0, `flag_f` to 0 and `busy` to 1 on that edge. `flag_e` keeps its previous value.
- R3: On each counting clock, `count` becomes its previous value plus one, modulo 2^CNT_W.
- R4: On each counting clock, `flag_e` takes the value of bit E_BIT (default 2) of the count before the edge. If that bit is 0, counting continues.
- R5: When bits STOP_BIT (default 3) and E_BIT of the pre-edge count are both 1 on a counting clock, the controller leaves counting. On the next edge `flag_f` becomes 1 and `busy` falls. With default parameters a run ends with `count` = 13, `flag_e` = 1 and `flag_f` = 1.
- R6: While idle without a start, `count`, `flag_e` and `flag_f` hold their values.
- R7: `start` has no effect while `busy` is 1. The run continues without clearing `count`.
- R8: `busy` is 1 exactly while the controller is in its counting or flag-setting state, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle |
| count | output | CNT_W | Counter value (registered) |
| flag_e | output | 1 | Step flag that follows counter bit E_BIT |
| flag_f | output | 1 | Terminating flag, set one clock after the stop condition |
| busy | output | 1 | High while a run is in progress |

## Verification
The bench runs a single start pulse through a complete run. Compared each clock against a behavioural model, this run separates the E-bit decisions (0 for counts 0–3 and 8–11, 1 for counts 4–7 and 12) from the stop decision at 12. A second run starts while E is still 1, which shows that start leaves E untouched. That run also pulses start in the middle of counting, which must not clear the counter. A start held high for many cycles produces back-to-back runs and checks that the idle state lasts exactly one cycle. A reset in the middle of a run confirms that the synchronous clear overrides everything else.

// File: rtl/ctr_flag_seq_pkg.sv
package ctr_flag_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SETF  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ctr_flag_seq_ctrl.sv
module ctr_flag_seq_ctrl
  import ctr_flag_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop_hit,
  output seq_state_t state,
  output logic       busy,
  output logic       do_clear,
  output logic       do_step,
  output logic       do_setf
);
  seq_state_t state_q, state_d;
  logic       busy_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)    state_d = ST_COUNT;
      ST_COUNT: if (stop_hit) state_d = ST_SETF;
      ST_SETF:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  assign do_clear = (state_q == ST_IDLE) && start;
  assign do_step  = (state_q == ST_COUNT);
  assign do_setf  = (state_q == ST_SETF);
  assign state    = state_q;
  assign busy     = busy_q;
endmodule

// File: rtl/ctr_flag_seq_dp.sv
module ctr_flag_seq_dp #(
  parameter int CNT_W    = 4,
  parameter int E_BIT    = 2,
  parameter int STOP_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_clear,
  input  logic             do_step,
  input  logic             do_setf,
  output logic             stop_hit,
  output logic [CNT_W-1:0] count,
  output logic             flag_e,
  output logic             flag_f
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             e_q, f_q;

  assign stop_hit = cnt_q[E_BIT] & cnt_q[STOP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      e_q   <= 1'b0;
      f_q   <= 1'b0;
    end else begin
      if (do_clear) begin
        cnt_q <= '0;
        f_q   <= 1'b0;
      end else if (do_step) begin
        cnt_q <= cnt_q + ONE;
        e_q   <= cnt_q[E_BIT];
      end else if (do_setf) begin
        f_q   <= 1'b1;
      end
    end
  end

  assign count  = cnt_q;
  assign flag_e = e_q;
  assign flag_f = f_q;
endmodule

// File: rtl/ctr_flag_seq.sv
module ctr_flag_seq
  import ctr_flag_seq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int E_BIT    = 2,
  parameter int STOP_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             flag_e,
  output logic             flag_f,
  output logic             busy
);
  seq_state_t state;
  logic       stop_hit, do_clear, do_step, do_setf;

  ctr_flag_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop_hit (stop_hit),
    .state    (state),
    .busy     (busy),
    .do_clear (do_clear),
    .do_step  (do_step),
    .do_setf  (do_setf)
  );

  ctr_flag_seq_dp #(
    .CNT_W    (CNT_W),
    .E_BIT    (E_BIT),
    .STOP_BIT (STOP_BIT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .do_clear (do_clear),
    .do_step  (do_step),
    .do_setf  (do_setf),
    .stop_hit (stop_hit),
    .count    (count),
    .flag_e   (flag_e),
    .flag_f   (flag_f)
  );
endmodule

// File: rtl/ctr_flag_seq_chk.sv
module ctr_flag_seq_chk
  import ctr_flag_seq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int E_BIT    = 2,
  parameter int STOP_BIT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             flag_e,
  input logic             flag_f,
  input logic             busy,
  input seq_state_t       state
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (count == '0 && !flag_e && !flag_f && !busy)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && start) |=> (count == '0 && !flag_f && busy && flag_e == $past(flag_e))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) (state == ST_COUNT) |=> (count == CNT_W'($past(count) + 1'b1))); // R3
  AST_E_TRACKS: assert property (@(posedge clk) disable iff (rst) (state == ST_COUNT) |=> (flag_e == $past(count[E_BIT]))); // R4
  AST_STOP_GO: assert property (@(posedge clk) disable iff (rst) (state == ST_COUNT && count[E_BIT] && count[STOP_BIT]) |=> (state == ST_SETF && !flag_f)); // R5
  AST_F_SET: assert property (@(posedge clk) disable iff (rst) (state == ST_SETF) |=> (flag_f && !busy && $stable(count))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && !start) |=> ($stable(count) && $stable(flag_e) && $stable(flag_f))); // R6
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst) (busy && start && state == ST_COUNT) |=> (count != '0 || $past(count) == '1)); // R7
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst) busy == (state != ST_IDLE)); // R8
endmodule

bind ctr_flag_seq ctr_flag_seq_chk #(
  .CNT_W    (CNT_W),
  .E_BIT    (E_BIT),
  .STOP_BIT (STOP_BIT)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .count  (count),
  .flag_e (flag_e),
  .flag_f (flag_f),
  .busy   (busy),
  .state  (state)
);

// File: tb/test_ctr_flag_seq.sv
module test_ctr_flag_seq;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] count;
  logic             flag_e, flag_f, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_st = 0, m_cnt = 0, m_e = 0, m_f = 0;

  always #10 clk = ~clk;

  ctr_flag_seq i_ctr_flag_seq (
    .clk(clk), .rst(rst), .start(start),
    .count(count), .flag_e(flag_e), .flag_f(flag_f), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit r, input bit s);
    int old_cnt;
    if (r) begin
      m_st = 0; m_cnt = 0; m_e = 0; m_f = 0;
    end else begin
      case (m_st)
        0: if (s) begin m_cnt = 0; m_f = 0; m_st = 1; end
        1: begin
          old_cnt = m_cnt;
          m_cnt = (old_cnt + 1) % 16;
          m_e = (old_cnt >> 2) & 1;
          if (((old_cnt >> 2) & 3) == 3) m_st = 2;
        end
        default: begin m_f = 1; m_st = 0; end
      endcase
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit r, input bit s);
    rst = r; start = s;
    @(posedge clk);
    model_edge(r, s);
    @(negedge clk);
    check("R3 R4 count", int'(count), m_cnt);
    check("R4 flag_e", int'(flag_e), m_e);
    check("R5 flag_f", int'(flag_f), m_f);
    check("R8 busy", int'(busy), (m_st != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step(1, 0);
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 busy", int'(busy), 0);
    // R6 idle hold
    repeat (3) step(0, 0);
    check("R6 count idle", int'(count), 0);
    // full run
    step(0, 1);
    check("R2 busy after start", int'(busy), 1);
    for (int i = 0; i < 18; i++) step(0, 0);
    check("R5 final count", int'(count), 13);
    check("R5 final e", int'(flag_e), 1);
    check("R5 final f", int'(flag_f), 1);
    check("R6 idle", int'(busy), 0);
    repeat (2) step(0, 0);
    check("R6 hold count", int'(count), 13);
    // second run: E must survive start
    step(0, 1);
    check("R2 e kept", int'(flag_e), 1);
    check("R2 f cleared", int'(flag_f), 0);
    check("R2 count cleared", int'(count), 0);
    repeat (5) step(0, 0);
    step(0, 1);
    check("R7 start ignored", int'(count), 6);
    step(0, 1);
    check("R7 start ignored again", int'(count), 7);
    for (int i = 0; i < 10; i++) step(0, 0);
    check("R5 second run f", int'(flag_f), 1);
    // start held high: back-to-back runs
    for (int i = 0; i < 40; i++) step(0, 1);
    // reset in the middle of a run
    step(0, 0);
    step(1, 1);
    check("R1 mid-run reset count", int'(count), 0);
    check("R1 mid-run reset busy", int'(busy), 0);
    check("R1 mid-run reset e", int'(flag_e), 0);
    for (int i = 0; i < 20; i++) step(0, (i == 2) ? 1'b1 : 1'b0);
    check("R5 run after reset", int'(count), 13);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule